// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM. It has a 19-bit address and an 8-bit data bus, which gives 524,288 locations. The host makes one single-beat request at a time over a valid/ready port. The request carries an address, a write flag and a byte of write data. The controller turns each request into the active-low chip-enable, output-enable and write-enable sequence that the memory expects. A read returns its byte on a one-cycle data-valid pulse. The memory data bus is split into an output, an output-enable and an input; the pad ring joins them.

Every analog timing of the memory is turned into a whole number of clock cycles when the design is built. Two parameters set this: the clock period in nanoseconds and the speed grade (55, 70, 85 or 100 ns). The strobe widths, the data setup, the minimum cycle time and the bus release time after a read all come from a table indexed by the speed grade. A low-power retention mode is also provided. While it is active, chip-enable is held inactive and an output asks for the supply rail to be lowered. When retention is left, a recovery wait of a parameterised length must expire before the host may issue the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1. All three memory strobes are high, `sram_dq_oe_o`, `rd_valid_o`, `ret_active_o` and `supply_low_o` are 0.
- R2: Each timing is converted to a cycle count as ceil(ns / CLK_PERIOD_NS), with a minimum of 1. With an 8 ns clock and grade 55 this gives: access 7, write strobe 7 (the larger of 50 ns and the 30 ns data setup), bus release 3, cycle 7.
- R3: A write holds chip-enable and write-enable low together, with output-enable high, for the write-strobe count of cycles. The byte is driven with `sram_dq_oe_o` high for the whole window, and `sram_addr_o` holds the request address.
- R4: A read holds chip-enable and output-enable low, with write-enable high, for the access count of cycles. The data byte is sampled on the clock edge that closes this window.
- R5: `rd_valid_o` is high for exactly one clock per read, in the cycle after the read strobes end, and `rd_data_o` carries the sampled byte. Writes never raise it.
- R6: `req_ready_o` is low from the cycle after acceptance until the access and its trailing gap are over. The write gap is max(1, cycle - strobe) cycles and the read gap is max(1, bus release, cycle - access) cycles. This gives 8 busy cycles per write and 10 per read at the defaults.
- R7: `sram_dq_oe_o` never rises until at least the bus-release count of cycles has passed since output-enable last went high. Write-enable and output-enable are never low together.
- R8: A retention request is taken only while idle. If a host request is present in the same cycle, the host access wins and retention is not entered.
- R9: In retention, `ret_active_o` and `supply_low_o` are high, chip-enable is held high and `req_ready_o` is low. Host requests start no memory cycle.
- R10: `ret_exit_i` drops `supply_low_o` and starts a recovery wait of ceil(RECOVERY_NS / CLK_PERIOD_NS) cycles. During the wait, chip-enable stays high and both `ret_active_o` and `req_ready_o` hold their retention values. After the wait the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write byte |
| rd_valid_o | output | 1 | One-cycle read-data-valid pulse |
| rd_data_o | output | DATA_W | Read byte |
| ret_req_i | input | 1 | Enter retention |
| ret_exit_i | input | 1 | Supply restored, start recovery |
| ret_active_o | output | 1 | Retention or recovery in progress |
| supply_low_o | output | 1 | Request to lower the memory supply |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Memory data out |
| sram_dq_i | input | DATA_W | Memory data in |
| sram_dq_oe_o | output | 1 | Drive enable for the data pads |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |

## Verification
The properties assume that `ret_exit_i` is only pulsed while retention is active, and that the memory model drives `sram_dq_i` only while chip-enable and output-enable are low and write-enable is high. The bench changes every host input half a cycle away from the sampling edge. It issues a request only after it has seen ready high, pulses the retention exit once inside the retention state, and models the memory as a combinational read of a small array with writes committed on strobe cycles. This keeps every input inside those assumptions.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_GAP,
    ST_RET,
    ST_RECOV
  } ctrl_state_e;

  function automatic int ns_to_cyc(input int ns, input int period);
    int r;
    r = (ns + period - 1) / period;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // unsupported grades fall back to the slowest table column
  function automatic int t_access_ns(input int g);
    case (g)
      55:      return 55;
      70:      return 70;
      85:      return 85;
      default: return 100;
    endcase
  endfunction

  function automatic int t_wpulse_ns(input int g);
    case (g)
      55:      return 50;
      70:      return 60;
      85:      return 70;
      default: return 80;
    endcase
  endfunction

  function automatic int t_dsetup_ns(input int g);
    case (g)
      55, 70:  return 30;
      85:      return 35;
      default: return 40;
    endcase
  endfunction

  function automatic int t_release_ns(input int g);
    case (g)
      55:      return 20;
      70:      return 25;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // a load of N makes done_o high in the Nth cycle after the load edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i - CNT_W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int N_WR  = 7,
  parameter int N_RD  = 7,
  parameter int GAP_W = 1,
  parameter int GAP_R = 3,
  parameter int N_REC = 625000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             ret_req_i,
  input  logic             ret_exit_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             ce_no,
  output logic             oe_no,
  output logic             we_no,
  output logic             dq_oe_o,
  output logic             ret_active_o,
  output logic             supply_low_o
);
  ctrl_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        // host access outranks retention entry
        if (req_valid_i) begin
          tmr_load_o = 1'b1;
          if (req_we_i) begin
            state_d   = ST_WR;
            tmr_val_o = CNT_W'(N_WR);
          end else begin
            state_d   = ST_RD;
            tmr_val_o = CNT_W'(N_RD);
          end
        end else if (ret_req_i) begin
          state_d = ST_RET;
        end
      end
      ST_WR: if (tmr_done_i) begin
        state_d    = ST_GAP;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(GAP_W);
      end
      ST_RD: if (tmr_done_i) begin
        state_d    = ST_GAP;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(GAP_R);
      end
      ST_GAP:   if (tmr_done_i) state_d = ST_IDLE;
      ST_RET: if (ret_exit_i) begin
        state_d    = ST_RECOV;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(N_REC);
      end
      ST_RECOV: if (tmr_done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign accept_o     = ready_o && req_valid_i;
  assign capture_o    = (state_q == ST_RD) && tmr_done_i;
  assign ce_no        = !((state_q == ST_WR) || (state_q == ST_RD));
  assign oe_no        = (state_q != ST_RD);
  assign we_no        = (state_q != ST_WR);
  assign dq_oe_o      = (state_q == ST_WR);
  assign ret_active_o = (state_q == ST_RET) || (state_q == ST_RECOV);
  assign supply_low_o = (state_q == ST_RET);
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_addr_o <= '0;
      sram_dq_o   <= '0;
    end else if (accept_i) begin
      sram_addr_o <= req_addr_i;
      sram_dq_o   <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= capture_i;
      if (capture_i) rd_data_o <= sram_dq_i;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 55,
  parameter int RECOVERY_NS   = 5000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ret_req_i,
  input  logic              ret_exit_i,
  output logic              ret_active_o,
  output logic              supply_low_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no
);
  localparam int N_RD  = ns_to_cyc(t_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int N_RC  = N_RD;
  localparam int N_WR  = max2(ns_to_cyc(t_wpulse_ns(SPEED_GRADE), CLK_PERIOD_NS),
                              ns_to_cyc(t_dsetup_ns(SPEED_GRADE), CLK_PERIOD_NS));
  localparam int N_HZ  = ns_to_cyc(t_release_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int GAP_W = max2(1, N_RC - N_WR);
  localparam int GAP_R = max2(N_HZ, max2(1, N_RC - N_RD));
  localparam int N_REC = ns_to_cyc(RECOVERY_NS, CLK_PERIOD_NS);
  localparam int CNT_MAX = max2(N_REC, max2(N_WR, max2(N_RD, GAP_R)));
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic             tmr_load, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_cycle_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_ctrl_fsm #(
    .CNT_W (CNT_W),
    .N_WR  (N_WR),
    .N_RD  (N_RD),
    .GAP_W (GAP_W),
    .GAP_R (GAP_R),
    .N_REC (N_REC)
  ) fsm_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_we_i     (req_we_i),
    .ret_req_i    (ret_req_i),
    .ret_exit_i   (ret_exit_i),
    .tmr_done_i   (tmr_done),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .accept_o     (accept),
    .capture_o    (capture),
    .ready_o      (req_ready_o),
    .ce_no        (sram_ce_no),
    .oe_no        (sram_oe_no),
    .we_no        (sram_we_no),
    .dq_oe_o      (sram_dq_oe_o),
    .ret_active_o (ret_active_o),
    .supply_low_o (supply_low_o)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .sram_dq_i   (sram_dq_i),
    .sram_addr_o (sram_addr_o),
    .sram_dq_o   (sram_dq_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 55
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic rd_valid_o,
  input logic ret_active_o,
  input logic supply_low_o,
  input logic sram_dq_oe_o,
  input logic sram_ce_no,
  input logic sram_oe_no,
  input logic sram_we_no
);
  localparam int N_RD = ns_to_cyc(t_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int N_WR = max2(ns_to_cyc(t_wpulse_ns(SPEED_GRADE), CLK_PERIOD_NS),
                             ns_to_cyc(t_dsetup_ns(SPEED_GRADE), CLK_PERIOD_NS));
  localparam int N_HZ = ns_to_cyc(t_release_ns(SPEED_GRADE), CLK_PERIOD_NS);

  logic [7:0] we_low_cnt, oe_low_cnt, oe_high_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt  <= '0;
      oe_low_cnt  <= '0;
      oe_high_cnt <= 8'hff;
    end else begin
      we_low_cnt  <= sram_we_no ? 8'd0 : ((we_low_cnt == 8'hff) ? we_low_cnt : we_low_cnt + 8'd1);
      oe_low_cnt  <= sram_oe_no ? 8'd0 : ((oe_low_cnt == 8'hff) ? oe_low_cnt : oe_low_cnt + 8'd1);
      oe_high_cnt <= !sram_oe_no ? 8'd0 : ((oe_high_cnt == 8'hff) ? oe_high_cnt : oe_high_cnt + 8'd1);
    end
  end

  assert_wr_strobe_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (int'(we_low_cnt) >= N_WR));

  assert_wr_bus_owned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (sram_dq_oe_o && !sram_ce_no && sram_oe_no));

  assert_rd_strobe_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> (int'(oe_low_cnt) >= N_RD));

  assert_rd_pins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> (!sram_ce_no && sram_we_no));

  assert_rvalid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  assert_busy_when_selected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no |-> !req_ready_o);

  assert_bus_turnaround_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (int'(oe_high_cnt) >= N_HZ));

  assert_no_strobe_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));

  assert_ret_deselect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_active_o |-> (sram_ce_no && !req_ready_o));

  assert_supply_in_ret_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_o |-> ret_active_o);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .SPEED_GRADE   (SPEED_GRADE)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rd_valid_o   (rd_valid_o),
  .ret_active_o (ret_active_o),
  .supply_low_o (supply_low_o),
  .sram_dq_oe_o (sram_dq_oe_o),
  .sram_ce_no   (sram_ce_no),
  .sram_oe_no   (sram_oe_no),
  .sram_we_no   (sram_we_no)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  localparam int PER  = 8;
  localparam int REC_NS = 2000;
  // expected cycle counts, grade 55 at 8 ns (R2)
  localparam int EXP_WR  = 7;
  localparam int EXP_RD  = 7;
  localparam int EXP_HZ  = 3;
  localparam int EXP_BUSY_WR = 8;
  localparam int EXP_BUSY_RD = 10;
  localparam int EXP_REC = (REC_NS + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0, ret_req = 1'b0, ret_exit = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid, ret_act, sup_low, dq_oe, ce_n, oe_n, we_n;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [18:0] s_addr;
  logic [7:0]  mem [256];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(55), .RECOVERY_NS(REC_NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wdata),
    .rd_valid_o(rvalid), .rd_data_o(rdata), .ret_req_i(ret_req), .ret_exit_i(ret_exit),
    .ret_active_o(ret_act), .supply_low_o(sup_low), .sram_addr_o(s_addr),
    .sram_dq_o(dq_o), .sram_dq_i(dq_i), .sram_dq_oe_o(dq_oe),
    .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n));

  // memory model
  assign dq_i = (!ce_n && !oe_n && we_n) ? mem[s_addr[7:0]] : 8'h5a;
  always @(posedge clk) if (!ce_n && !we_n && dq_oe) mem[s_addr[7:0]] <= dq_o;

  // turnaround monitor: oe-high cycles before dq_oe rises
  int since_oe = 100, last_turn = -1;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!oe_n) since_oe <= 0;
    else if (dq_oe && !prev_oe) last_turn <= since_oe;
    else since_oe <= since_oe + 1;
    prev_oe <= dq_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [18:0] a, input logic [7:0] d,
                        output int busy, output int strb, output int rv,
                        output logic [7:0] rd, output bit pins_ok);
    busy = 0; strb = 0; rv = 0; rd = '0; pins_ok = 1'b1;
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0;
    while (!ready) begin
      busy++;
      if (w && !we_n) begin
        strb++;
        if (!(dq_oe && oe_n && !ce_n && s_addr == a && dq_o == d)) pins_ok = 1'b0;
      end
      if (!w && !oe_n) begin
        strb++;
        if (!(we_n && !ce_n && !dq_oe && s_addr == a)) pins_ok = 1'b0;
      end
      if (rvalid) begin rv++; rd = rdata; end
      @(negedge clk);
    end
    if (rvalid) rv++;
  endtask

  typedef logic [27:0] vec_t;  // {write, addr[18:0], data[7:0]}
  localparam vec_t VEC [10] = '{
    {1'b1, 19'h7ffff, 8'ha5}, {1'b1, 19'h00000, 8'h3c}, {1'b1, 19'h12345, 8'hff},
    {1'b0, 19'h7ffff, 8'ha5}, {1'b0, 19'h00000, 8'h3c}, {1'b1, 19'h12345, 8'h00},
    {1'b0, 19'h12345, 8'h00}, {1'b1, 19'h40001, 8'h81}, {1'b0, 19'h40001, 8'h81},
    {1'b0, 19'h12345, 8'h00}};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int busy, strb, rv, cnt;
    logic [7:0] rd;
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ready && ce_n && oe_n && we_n && !dq_oe && !rvalid && !ret_act && !sup_low,
        "R1 reset outputs", {ready, ce_n, oe_n, we_n, dq_oe, rvalid, ret_act, sup_low}, 8'b11110000);

    // table walk
    for (int i = 0; i < 10; i++) begin
      access(VEC[i][27], VEC[i][26:8], VEC[i][7:0], busy, strb, rv, rd, ok);
      if (VEC[i][27]) begin
        chk(strb == EXP_WR, "R2 R3 write strobe cycles", strb, EXP_WR);
        chk(ok, "R3 write pins/addr/data", ok, 1);
        chk(rv == 0, "R5 no valid on write", rv, 0);
        chk(busy == EXP_BUSY_WR, "R6 write busy cycles", busy, EXP_BUSY_WR);
      end else begin
        chk(strb == EXP_RD, "R2 R4 read strobe cycles", strb, EXP_RD);
        chk(ok, "R4 read pins/addr", ok, 1);
        chk(rv == 1, "R5 one valid pulse", rv, 1);
        chk(rd == VEC[i][7:0], "R4 R5 read data", rd, VEC[i][7:0]);
        chk(busy == EXP_BUSY_RD, "R6 read busy cycles", busy, EXP_BUSY_RD);
      end
    end

    // R7 read then write back to back
    access(1'b0, 19'h00000, 8'h00, busy, strb, rv, rd, ok);
    access(1'b1, 19'h00010, 8'h77, busy, strb, rv, rd, ok);
    chk(last_turn >= EXP_HZ, "R7 bus turnaround", last_turn, EXP_HZ);

    // R8 simultaneous host and retention request: host wins
    @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = 19'h00010; ret_req = 1'b1;
    @(negedge clk);
    valid = 1'b0; ret_req = 1'b0;
    chk(!ret_act && !oe_n, "R8 host wins over retention", {ret_act, oe_n}, 0);
    while (!ready) @(negedge clk);
    chk(rdata == 8'h77, "R8 read completed", rdata, 8'h77);

    // R9 retention entry
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    chk(ret_act && sup_low && ce_n && !ready, "R9 retention outputs",
        {ret_act, sup_low, ce_n, ready}, 4'b1110);
    valid = 1'b1; we = 1'b1; addr = 19'h00010; wdata = 8'hee;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!ce_n || !ready == 1'b0) cnt++;
    end
    valid = 1'b0;
    chk(cnt == 0, "R9 deselected and busy during retention", cnt, 0);

    // R10 exit and recovery
    ret_exit = 1'b1;
    @(negedge clk);
    ret_exit = 1'b0;
    chk(!sup_low && ret_act, "R10 supply restored, still active", {sup_low, ret_act}, 2'b01);
    busy = 0; cnt = 0;
    while (!ready) begin
      busy++;
      if (!ce_n) cnt++;
      @(negedge clk);
    end
    chk(busy == EXP_REC, "R10 recovery cycles", busy, EXP_REC);
    chk(cnt == 0 && !ret_act, "R10 no select in recovery, flag clear after", cnt, 0);

    // R9 host write during retention left memory untouched
    access(1'b0, 19'h00010, 8'h00, busy, strb, rv, rd, ok);
    chk(rd == 8'h77, "R9 request during retention ignored", rd, 8'h77);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule